// File: doc/BRIEF.md
# Radix-2 Twiddle Address Sequencer

This block feeds the phase-factor ROM ports of a folded, constant-geometry radix-2 FFT engine with P butterflies working side by side. On every internal step of every stage it produces, for each butterfly lane, the index of the twiddle factor W_N^k that lane needs. It does not multiply, store coefficients or move data. It only sequences addresses.

Only a quarter period of the coefficients is meant to be held in ROM. The exponent space k = 0 .. N/2-1 is treated as twice the physical ROM depth N/4. The top bit of k is passed out as a separate select flag, which tells the datapath to use the quarter-wave symmetry relation instead of a direct lookup.

Inside the block, three per-stage quantities build the address:
- a stride that is added to the base;
- a rate, which is the number of steps between stride additions;
- a lane-sharing width, which sets which lanes start from a common offset and how far apart the start offsets are.

Each of these registers shrinks on its own schedule when a stage completes. The controller drives the stage and step indices in order and pulses `start` at the beginning of every transform.

Top module: `twiddle_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released, `addr_valid` is 0 and every lane's `rom_addr` and `sym_sel` are 0.
- R2: In stage 0 every lane receives exponent k = 0 (rom_addr 0, sym_sel 0) on every step.
- R3: For an accepted step (en=1, start=0) with step index b in stage i, lane p outputs exponent k = floor(j / 2^(S-1-i)) * 2^(S-1-i), where j = b*P + p and S = log2 N. The lanes carry nondecreasing k from lane 0 upward.
- R4: The outputs are registered. `addr_valid` is 1 exactly in the cycle after an accepted step. After a cycle with en=0 or start=1, `addr_valid` is 0 and the addresses and flags keep their previous values.
- R5: A `start` pulse at any time, including in the middle of a transform, reloads the stage-0 parameters. The following steps follow the stage-0 pattern.
- R6: Cycles with en=0 inserted between steps, including while the last step index of a stage is presented, neither advance the stage parameters nor change the address sequence.
- R7: In the last stage (i = S-1) lane p outputs k = b*P + p.
- R8: For each lane, `rom_addr` carries k mod N/4 in lane slice [p*(S-2) +: S-2] and `sym_sel[p]` carries bit S-2 of k (1 when k >= N/4).
- R9: The parameters advance only on an accepted step whose step index is N/(2P)-1 and whose stage index is not S-1. Repeating last-stage steps keeps producing the last-stage pattern until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a new transform; reloads stage-0 parameters |
| en | input | 1 | Accepts the step presented on the index inputs |
| stage_idx | input | clog2(log2 N) | Current stage index, 0 .. log2 N - 1 |
| step_idx | input | max(log2(N/2P),1) | Internal step within the stage, 0 .. N/(2P)-1 |
| rom_addr | output | P*(log2 N - 2) | Per-lane quarter-wave ROM index, lane p in slice p |
| sym_sel | output | P | Per-lane symmetry select (exponent top bit) |
| addr_valid | output | 1 | Addresses updated in this cycle |

## Verification
The bench goes after the points where the three parameters change on different schedules. If the stride stopped at the wrong floor, the middle stages would jump by the wrong amount between address changes. If the lane-sharing width shrank too early, lanes that should share a start value would split in the stages before the rate reaches one. The bench also repeats last-stage steps, holds `en` low on a stage's final step, and restarts in the middle of a transform. A design that advanced its parameters on those cycles, or that did not reload on `start`, would go out of sync with the index inputs and emit the pattern of a later stage. The flag split at N/4 is compared on every lane, which catches a wrong symmetry-bit position.

// File: rtl/twa_pkg.sv
package twa_pkg;

  // Width of the per-stage parameters, which are kept as base-2 logarithms.
  typedef logic [7:0] log_t;

  // Decrement toward a floor, only when asked.
  function automatic log_t sat_down(input log_t v, input log_t lo, input logic go);
    if (go && (v > lo)) return v - log_t'(1);
    return v;
  endfunction

endpackage

// File: rtl/twa_stage_params.sv
module twa_stage_params
  import twa_pkg::*;
#(
  parameter int unsigned S = 6,
  parameter int unsigned L = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic advance,
  output log_t freq_log,
  output log_t step_log,
  output log_t hold_log
);

  localparam log_t FREQ_INIT = log_t'(S - 1 - L);
  localparam log_t STEP_INIT = log_t'(S - 1);
  localparam log_t HOLD_INIT = log_t'(L);
  localparam log_t STEP_FLOOR = log_t'(L);

  log_t freq_q, step_q, hold_q;
  log_t freq_d, step_d, hold_d;

  // Next state: the rate and stride halve on their own, and the sharing
  // width starts to shrink once the stride has reached its floor.
  always_comb begin
    freq_d = freq_q;
    step_d = step_q;
    hold_d = hold_q;
    if (start) begin
      freq_d = FREQ_INIT;
      step_d = STEP_INIT;
      hold_d = HOLD_INIT;
    end else if (advance) begin
      freq_d = sat_down(freq_q, '0, 1'b1);
      step_d = sat_down(step_q, STEP_FLOOR, 1'b1);
      hold_d = sat_down(hold_q, '0, (step_q == STEP_FLOOR));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q <= FREQ_INIT;
      step_q <= STEP_INIT;
      hold_q <= HOLD_INIT;
    end else if (start || advance) begin
      freq_q <= freq_d;
      step_q <= step_d;
      hold_q <= hold_d;
    end
  end

  assign freq_log = freq_q;
  assign step_log = step_q;
  assign hold_log = hold_q;

endmodule

// File: rtl/twa_lane_addr.sv
module twa_lane_addr
  import twa_pkg::*;
#(
  parameter int unsigned AW     = 5,
  parameter int unsigned STEP_W = 3,
  parameter int unsigned LANE   = 0
) (
  input  logic [STEP_W-1:0] step_idx,
  input  log_t              freq_log,
  input  log_t              step_log,
  input  log_t              hold_log,
  output logic [AW-1:0]     k_out
);

  logic [AW-1:0] b_ext;
  logic [AW-1:0] lane_c;
  logic [AW-1:0] base;
  logic [AW-1:0] offset;

  always_comb begin
    b_ext  = AW'(step_idx);
    lane_c = AW'(LANE);
    // Add the stride once per 2^freq_log steps.
    base   = (b_ext >> freq_log) << step_log;
    // Lanes inside one 2^hold_log group share a start offset.
    offset = (lane_c >> hold_log) << hold_log;
    k_out  = base | offset;
  end

endmodule

// File: rtl/twiddle_addr_seq.sv
module twiddle_addr_seq
  import twa_pkg::*;
#(
  parameter int unsigned N = 64,
  parameter int unsigned P = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic                                 en,
  input  logic [$clog2($clog2(N))-1:0]         stage_idx,
  input  logic [((($clog2(N)-1-$clog2(P)) > 0) ? ($clog2(N)-1-$clog2(P)) : 1)-1:0] step_idx,
  output logic [P*($clog2(N)-2)-1:0]           rom_addr,
  output logic [P-1:0]                         sym_sel,
  output logic                                 addr_valid
);

  localparam int unsigned S      = $clog2(N);
  localparam int unsigned L      = $clog2(P);
  localparam int unsigned M      = N / (2 * P);
  localparam int unsigned AW     = S - 1;
  localparam int unsigned RW     = S - 2;
  localparam int unsigned STG_W  = $clog2(S);
  localparam int unsigned STEP_W = ((S - 1 - L) > 0) ? (S - 1 - L) : 1;

  logic advance;
  logic accept;
  log_t freq_log, step_log, hold_log;

  logic [P*AW-1:0] k_comb;
  logic [P*AW-1:0] k_q, k_d;
  logic            valid_q, valid_d;

  assign accept  = en && !start;
  assign advance = accept
                && (step_idx == STEP_W'(M - 1))
                && (stage_idx != STG_W'(S - 1));

  twa_stage_params #(.S(S), .L(L)) u_params (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .advance  (advance),
    .freq_log (freq_log),
    .step_log (step_log),
    .hold_log (hold_log)
  );

  for (genvar p = 0; p < P; p++) begin : g_lane
    twa_lane_addr #(.AW(AW), .STEP_W(STEP_W), .LANE(p)) u_lane (
      .step_idx (step_idx),
      .freq_log (freq_log),
      .step_log (step_log),
      .hold_log (hold_log),
      .k_out    (k_comb[p*AW +: AW])
    );
    assign rom_addr[p*RW +: RW] = k_q[p*AW +: RW];
    assign sym_sel[p]           = k_q[p*AW + AW - 1];
  end

  always_comb begin
    k_d     = k_q;
    valid_d = 1'b0;
    if (accept) begin
      k_d     = k_comb;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q     <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (accept) k_q <= k_d;
    end
  end

  assign addr_valid = valid_q;

endmodule

// File: rtl/twa_chk.sv
module twa_chk #(
  parameter int unsigned N = 64,
  parameter int unsigned P = 4
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 start,
  input logic                                 en,
  input logic [$clog2($clog2(N))-1:0]         stage_idx,
  input logic [((($clog2(N)-1-$clog2(P)) > 0) ? ($clog2(N)-1-$clog2(P)) : 1)-1:0] step_idx,
  input logic [P*($clog2(N)-2)-1:0]           rom_addr,
  input logic [P-1:0]                         sym_sel,
  input logic                                 addr_valid
);

  localparam int unsigned S     = $clog2(N);
  localparam int unsigned AW    = S - 1;
  localparam int unsigned RW    = S - 2;
  localparam int unsigned STG_W = $clog2(S);

  logic [AW-1:0] full_a [P];
  for (genvar p = 0; p < P; p++) begin : g_full
    assign full_a[p] = {sym_sel[p], rom_addr[p*RW +: RW]};
  end

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start || !en) |=> !addr_valid);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start || !en) |=> ($stable(rom_addr) && $stable(sym_sel)));

  assert_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !start) |=> addr_valid);

  assert_first_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !start && stage_idx == '0) |=> (rom_addr == '0 && sym_sel == '0));

  assert_last_stage_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !start && stage_idx == STG_W'(S - 1))
      |=> (full_a[0] == AW'(32'($past(step_idx)) * P)));

  // R3: lane exponents never decrease from lane 0 upward.
  always_ff @(posedge clk) begin
    if (rst_n && addr_valid) begin
      for (int p = 1; p < P; p++) begin
        assert_lane_order_R3: assert (full_a[p] >= full_a[p-1]);
      end
    end
  end

endmodule

bind twiddle_addr_seq twa_chk #(.N(N), .P(P)) u_chk (.*);

// File: tb/sim_twiddle_addr_seq.sv
`timescale 1ns/1ps
module sim_twiddle_addr_seq;

  localparam int N      = 64;
  localparam int P      = 4;
  localparam int S      = $clog2(N);
  localparam int L      = $clog2(P);
  localparam int M      = N / (2 * P);
  localparam int RW     = S - 2;
  localparam int STG_W  = $clog2(S);
  localparam int STEP_W = ((S - 1 - L) > 0) ? (S - 1 - L) : 1;

  logic clk = 1'b0;
  logic rst_n;
  logic start, en;
  logic [STG_W-1:0]  stage_idx;
  logic [STEP_W-1:0] step_idx;
  logic [P*RW-1:0]   rom_addr;
  logic [P-1:0]      sym_sel;
  logic              addr_valid;

  always #10 clk = ~clk;

  twiddle_addr_seq #(.N(N), .P(P)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .en(en),
    .stage_idx(stage_idx), .step_idx(step_idx),
    .rom_addr(rom_addr), .sym_sel(sym_sel), .addr_valid(addr_valid)
  );

  int checks = 0;
  int errors = 0;
  int ms = 0;
  int exp_k [P];
  logic exp_v = 1'b0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare(input string tag, input int used_stage);
    string atag;
    atag = tag;
    if (tag == "R3") atag = (used_stage == 0) ? "R2" : ((used_stage == S-1) ? "R7" : "R3");
    chk("R4", "valid", int'(addr_valid), int'(exp_v));
    for (int p = 0; p < P; p++) begin
      chk(atag, $sformatf("lane %0d rom", p), int'(rom_addr[p*RW +: RW]), exp_k[p] % (N/4));
      chk("R8", $sformatf("lane %0d sym", p), int'(sym_sel[p]), (exp_k[p] >> (S-2)) & 1);
    end
  endtask

  task automatic cyc(input logic s, input logic e, input int st, input int b, input string tag);
    int used;
    start = s; en = e; stage_idx = STG_W'(st); step_idx = STEP_W'(b);
    @(posedge clk);
    used = ms;
    if (s) begin
      exp_v = 1'b0;
      ms = 0;
    end else if (e) begin
      exp_v = 1'b1;
      for (int p = 0; p < P; p++) begin
        int sh = S - 1 - ms;
        exp_k[p] = ((b * P + p) >> sh) << sh;
      end
      if (b == M-1 && st != S-1 && ms < S-1) ms++;
    end else begin
      exp_v = 1'b0;
    end
    @(negedge clk);
    compare(tag, used);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog actual expired expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; en = 1'b0; stage_idx = '0; step_idx = '0;
    for (int p = 0; p < P; p++) exp_k[p] = 0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while in reset
    chk("R1", "valid in reset", int'(addr_valid), 0);
    chk("R1", "rom in reset", int'(rom_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid after reset", int'(addr_valid), 0);
    chk("R1", "sym after reset", int'(sym_sel), 0);

    // Full transform, every stage and step
    cyc(1, 0, 0, 0, "R5");
    for (int st = 0; st < S; st++)
      for (int b = 0; b < M; b++) cyc(0, 1, st, b, "R3");

    // R9: repeat last stage steps, parameters must stay put
    for (int r = 0; r < 2; r++)
      for (int b = 0; b < M; b++) cyc(0, 1, S-1, b, "R9");

    // R5: restart in the middle of a transform
    cyc(1, 0, 0, 0, "R5");
    for (int st = 0; st < 2; st++)
      for (int b = 0; b < M; b++) cyc(0, 1, st, b, "R5");
    cyc(0, 1, 2, 0, "R5");
    cyc(1, 0, 0, 0, "R5");
    for (int st = 0; st < S; st++)
      for (int b = 0; b < M; b++) cyc(0, 1, st, b, "R5");

    // R6: idle cycles between steps, including on each stage's last step
    cyc(1, 0, 0, 0, "R6");
    for (int st = 0; st < S; st++)
      for (int b = 0; b < M; b++) begin
        cyc(0, 0, st, b, "R6");
        cyc(0, 1, st, b, "R6");
        cyc(0, 0, st, b, "R6");
      end

    // Start and enable together: start wins, no output update
    cyc(1, 1, 0, M-1, "R5");
    for (int b = 0; b < M; b++) cyc(0, 1, 0, b, "R3");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule